// File: doc/BRIEF.md
# Probabilistic Register Bit-Flip Injector

This block holds a small bank of data registers and can corrupt what is read from them, to study how software copes with soft errors. Each register has its own random source, an activation threshold, a hold length and an operating mode. Every time the core signals that an instruction has retired, each register may start a fault. On a fault, the whole register reads back as all zeros or all ones, and a second random value picks which. The forced value lasts for one or more retired instructions, and the stored contents stay untouched underneath.

The three active modes cover the usual fault classes. A transient register fires at most once until it is set up again. An intermittent register is tested again on every retire that is not inside a hold. A latching register keeps its first fault until it is set up again. The random sources are linear feedback shift registers loaded from a programmable seed, so a run with the same seed and stimulus repeats exactly. A sticky flag per register records that a fault has fired.

Top module: `bitflip_injector`

## Requirements
- R1: After reset every register reads 0, no register is forced and every hit flag is 0.
- R2: A write with `wr_en` stores `wr_data` into register `wr_idx` at the clock edge. `rd_data` shows register `rd_idx` combinationally whenever that register is not forced.
- R3: Register i owns a 16-bit generator whose next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}. All generators advance once on each cycle with `retire` high. Loading `seed_we` sets generator i to `seed` XOR i, or to 1 if that gives 0, and takes priority over a retire in the same cycle. After reset the same rule applies with seed 16'hACE1.
- R4: At a retire where register i may be tested, the fault fires only if s[7:0] of its generator (the value before the step) is strictly below the 9-bit threshold. A threshold of 0 never fires and a threshold of 256 always fires.
- R5: When the fault fires, the register reads all zeros if s[15:8] is at most 128, and all ones otherwise.
- R6: A fault that fires with hold value h forces reads for the next h+1 retires. The register is released at the (h+1)-th retire unless a new fault fires in that same retire. A register inside a hold is not tested.
- R7: Mode 2'b01 (transient) lets the register fire at most once until its configuration is next written.
- R8: Mode 2'b10 (intermittent) tests the register on every retire that does not fall inside a hold, and fires only on a retire.
- R9: Mode 2'b11 (latching) keeps the first fault forced on every later retire until the register's configuration is written.
- R10: Mode 2'b00 (off) never fires, whatever the threshold.
- R11: The hit flag of a register is set when its fault fires and stays set. A configuration write to that register (`cfg_we`, `cfg_idx`) clears it, ends any forcing, re-arms transient mode and loads the new threshold, hold and mode.
- R12: Forcing affects reads only. A write during a fault updates the stored value, and that value reads back once the fault is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 2 | Register written |
| wr_data | input | 16 | Write data |
| rd_idx | input | 2 | Register read |
| rd_data | output | 16 | Read data, with any fault applied |
| retire | input | 1 | One pulse per retired instruction |
| cfg_we | input | 1 | Configuration write for one register |
| cfg_idx | input | 2 | Register being configured |
| cfg_thresh | input | 9 | Activation threshold (0 to 256) |
| cfg_hold | input | 4 | Extra retires a fault lasts |
| cfg_mode | input | 2 | 00 off, 01 transient, 10 intermittent, 11 latching |
| seed_we | input | 1 | Load all random generators from `seed` |
| seed | input | 16 | Generator seed |
| hit_flags | output | 4 | Sticky per-register fired flags |

## Verification
The main function is tried with intermittent thresholds near one half and one quarter. These show whether the compare is strict and whether both polarities occur. Always-fire thresholds in each mode separate transient, intermittent and latching behaviour and the hold count. Zero thresholds and the off mode with a full threshold confirm that no fault leaks out. Every retire is checked against a model of the generators, which pins down the draw taken before each step. A seed of zero checks the zero-state substitution. A write made during a latched fault, followed by a reconfiguration, shows that only reads are corrupted.

// File: rtl/bitflip_pkg.sv
package bitflip_pkg;
    typedef enum logic [1:0] {
        FM_OFF    = 2'b00,
        FM_ONCE   = 2'b01,
        FM_REPEAT = 2'b10,
        FM_LATCH  = 2'b11
    } fmode_e;
endpackage

// File: rtl/bitflip_lfsr.sv
module bitflip_lfsr #(
    parameter int          LW        = 16,
    parameter logic [LW-1:0] TAPS    = 16'hB400,
    parameter logic [LW-1:0] SEED_INIT = 16'hACE1,
    parameter int          LANE      = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] seed,
    input  logic          step,
    output logic [LW-1:0] state
);
    localparam logic [LW-1:0] LANE_V = LW'(LANE);

    function automatic logic [LW-1:0] mix(input logic [LW-1:0] s);
        logic [LW-1:0] m;
        m = s ^ LANE_V;
        return (m == '0) ? LW'(1) : m;
    endfunction

    logic [LW-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)
            st_d = mix(seed);
        else if (step)
            st_d = {st_q[LW-2:0], ^(st_q & TAPS)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= mix(SEED_INIT);
        else        st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/bitflip_slot.sv
module bitflip_slot
    import bitflip_pkg::*;
#(
    parameter int RW    = 8,
    parameter int HOLDW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [RW:0]      cfg_thresh,
    input  logic [HOLDW-1:0] cfg_hold,
    input  logic [1:0]       cfg_mode,
    input  logic             retire,
    input  logic [RW-1:0]    act_draw,
    input  logic [RW-1:0]    pol_draw,
    output logic             fire,
    output logic             force_on,
    output logic             force_val,
    output logic             latched,
    output logic             thr_zero,
    output logic             mode_off,
    output logic             hit
);
    localparam logic [RW-1:0] HALF = RW'(1) << (RW - 1);

    typedef struct packed {
        logic [RW:0]      thr;
        logic [HOLDW-1:0] hold;
        fmode_e           mode;
        logic             on;
        logic             val;
        logic [HOLDW-1:0] cnt;
        logic             used;
        logic             perm;
        logic             hit;
    } slot_t;

    slot_t s_d, s_q;
    logic  may_test;

    always_comb begin
        s_d      = s_q;
        fire     = 1'b0;
        may_test = (s_q.mode != FM_OFF) && !((s_q.mode == FM_ONCE) && s_q.used);
        if (cfg_wr) begin
            s_d.thr  = cfg_thresh;
            s_d.hold = cfg_hold;
            s_d.mode = fmode_e'(cfg_mode);
            s_d.on   = 1'b0;
            s_d.val  = 1'b0;
            s_d.cnt  = '0;
            s_d.used = 1'b0;
            s_d.perm = 1'b0;
            s_d.hit  = 1'b0;
        end else if (retire && !s_q.perm) begin
            if (s_q.on && (s_q.cnt != '0)) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end else begin
                s_d.on = 1'b0;
                if (may_test && ({1'b0, act_draw} < s_q.thr)) begin
                    fire     = 1'b1;
                    s_d.on   = 1'b1;
                    s_d.val  = (pol_draw > HALF);
                    s_d.cnt  = s_q.hold;
                    s_d.used = 1'b1;
                    s_d.hit  = 1'b1;
                    s_d.perm = (s_q.mode == FM_LATCH);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{thr: '0, hold: '0, mode: FM_OFF, on: 1'b0, val: 1'b0,
                            cnt: '0, used: 1'b0, perm: 1'b0, hit: 1'b0};
        else        s_q <= s_d;
    end

    assign force_on  = s_q.on;
    assign force_val = s_q.val;
    assign latched   = s_q.perm;
    assign thr_zero  = (s_q.thr == '0);
    assign mode_off  = (s_q.mode == FM_OFF);
    assign hit       = s_q.hit;
endmodule

// File: rtl/bitflip_injector.sv
module bitflip_injector #(
    parameter int              NREG      = 4,
    parameter int              WIDTH     = 16,
    parameter int              RW        = 8,
    parameter int              LW        = 16,
    parameter logic [LW-1:0]   TAPS      = 16'hB400,
    parameter logic [LW-1:0]   SEED_INIT = 16'hACE1,
    parameter int              HOLDW     = 4,
    parameter int              IW        = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data,
    input  logic             retire,
    input  logic             cfg_we,
    input  logic [IW-1:0]    cfg_idx,
    input  logic [RW:0]      cfg_thresh,
    input  logic [HOLDW-1:0] cfg_hold,
    input  logic [1:0]       cfg_mode,
    input  logic             seed_we,
    input  logic [LW-1:0]    seed,
    output logic [NREG-1:0]  hit_flags
);
    typedef struct packed {
        logic [NREG-1:0][WIDTH-1:0] regs;
    } bank_t;

    bank_t                     bank_d, bank_q;
    logic [NREG-1:0]           cfg_sel;
    logic [NREG-1:0]           fire_vec, force_vec, forceval_vec;
    logic [NREG-1:0]           perm_vec, thr_zero_vec, off_vec;
    logic [NREG-1:0][LW-1:0]   lane;

    always_comb begin
        cfg_sel = '0;
        if (cfg_we) cfg_sel[cfg_idx] = 1'b1;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        bitflip_lfsr #(
            .LW(LW), .TAPS(TAPS), .SEED_INIT(SEED_INIT), .LANE(g)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (seed_we),
            .seed  (seed),
            .step  (retire),
            .state (lane[g])
        );

        bitflip_slot #(.RW(RW), .HOLDW(HOLDW)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_wr     (cfg_sel[g]),
            .cfg_thresh (cfg_thresh),
            .cfg_hold   (cfg_hold),
            .cfg_mode   (cfg_mode),
            .retire     (retire),
            .act_draw   (lane[g][RW-1:0]),
            .pol_draw   (lane[g][LW-1 -: RW]),
            .fire       (fire_vec[g]),
            .force_on   (force_vec[g]),
            .force_val  (forceval_vec[g]),
            .latched    (perm_vec[g]),
            .thr_zero   (thr_zero_vec[g]),
            .mode_off   (off_vec[g]),
            .hit        (hit_flags[g])
        );
    end

    always_comb begin
        bank_d = bank_q;
        if (wr_en) bank_d.regs[wr_idx] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        if (force_vec[rd_idx]) rd_data = {WIDTH{forceval_vec[rd_idx]}};
        else                   rd_data = bank_q.regs[rd_idx];
    end
endmodule

// File: rtl/bitflip_injector_chk.sv
module bitflip_injector_chk #(
    parameter int NREG  = 4,
    parameter int WIDTH = 16,
    parameter int IW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             retire,
    input logic             cfg_we,
    input logic [IW-1:0]    cfg_idx,
    input logic [IW-1:0]    rd_idx,
    input logic [WIDTH-1:0] rd_data,
    input logic [NREG-1:0]  fire_vec,
    input logic [NREG-1:0]  force_vec,
    input logic [NREG-1:0]  perm_vec,
    input logic [NREG-1:0]  thr_zero_vec,
    input logic [NREG-1:0]  off_vec,
    input logic [NREG-1:0]  hit_flags
);
    logic [NREG-1:0] clr;
    always_comb begin
        clr = '0;
        if (cfg_we) clr[cfg_idx] = 1'b1;
    end

    p_fire_on_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_vec != '0) |-> retire);

    p_zero_thresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_vec & thr_zero_vec) == '0);

    p_mode_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_vec & off_vec) == '0);

    p_fire_forces_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_vec != '0) |=> (($past(fire_vec) & ~force_vec) == '0));

    p_hit_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_flags != '0) |=> ((($past(hit_flags) & ~$past(clr)) & ~hit_flags) == '0));

    p_perm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((perm_vec & ~clr) != '0) |=> (($past(perm_vec & ~clr) & ~force_vec) == '0));

    p_forced_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        force_vec[rd_idx] |-> ((rd_data == '0) || (rd_data == '1)));
endmodule

bind bitflip_injector bitflip_injector_chk #(.NREG(NREG), .WIDTH(WIDTH), .IW(IW)) u_chk (.*);

// File: tb/bitflip_injector_tb.sv
module bitflip_injector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        retire = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [8:0]  cfg_thresh = '0;
    logic [3:0]  cfg_hold = '0;
    logic [1:0]  cfg_mode = '0;
    logic        seed_we = 1'b0;
    logic [15:0] seed = '0;
    logic [3:0]  hit_flags;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bitflip_injector u_dut (.*);

    // Independent model built from the requirements
    logic [15:0] m_lane [4];
    logic [15:0] m_mem  [4];
    logic        m_on [4], m_val [4], m_used [4], m_perm [4], m_hit [4];
    logic [3:0]  m_cnt [4], m_hold [4];
    logic [1:0]  m_mode [4];
    logic [8:0]  m_thr [4];

    function automatic logic [15:0] lane_seed(input logic [15:0] s, input int i);
        logic [15:0] m;
        m = s ^ 16'(i);
        return (m == 16'h0) ? 16'h1 : m;
    endfunction

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_lane[i] = lane_seed(16'hACE1, i);
            m_mem[i] = '0; m_on[i] = 0; m_val[i] = 0; m_used[i] = 0;
            m_perm[i] = 0; m_hit[i] = 0; m_cnt[i] = 0; m_hold[i] = 0;
            m_mode[i] = 0; m_thr[i] = 0;
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_reg(input int i, input string tag);
        logic [15:0] e;
        rd_idx = 2'(i);
        #0.5;
        e = m_on[i] ? {16{m_val[i]}} : m_mem[i];
        check(rd_data == e, tag, 32'(rd_data), 32'(e));
    endtask

    task automatic check_all(input string tag);
        logic [3:0] eh;
        for (int i = 0; i < 4; i++) check_reg(i, tag);
        for (int i = 0; i < 4; i++) eh[i] = m_hit[i];
        check(hit_flags == eh, "R11 hit flags", 32'(hit_flags), 32'(eh));
    endtask

    task automatic do_write(input int i, input logic [15:0] d);
        wr_en = 1; wr_idx = 2'(i); wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 0;
        m_mem[i] = d;
    endtask

    task automatic do_cfg(input int i, input logic [1:0] md, input logic [8:0] th, input logic [3:0] hd);
        cfg_we = 1; cfg_idx = 2'(i); cfg_mode = md; cfg_thresh = th; cfg_hold = hd;
        @(posedge clk); @(negedge clk);
        cfg_we = 0;
        m_mode[i] = md; m_thr[i] = th; m_hold[i] = hd;
        m_on[i] = 0; m_val[i] = 0; m_cnt[i] = 0; m_used[i] = 0; m_perm[i] = 0; m_hit[i] = 0;
    endtask

    task automatic do_seed(input logic [15:0] s);
        seed_we = 1; seed = s;
        @(posedge clk); @(negedge clk);
        seed_we = 0;
        for (int i = 0; i < 4; i++) m_lane[i] = lane_seed(s, i);
    endtask

    task automatic do_retire();
        retire = 1;
        @(posedge clk); @(negedge clk);
        retire = 0;
        for (int i = 0; i < 4; i++) begin
            if (m_perm[i]) begin
            end else if (m_on[i] && m_cnt[i] != 0) begin
                m_cnt[i] = m_cnt[i] - 1;
            end else begin
                m_on[i] = 0;
                if (m_mode[i] != 2'b00 && !(m_mode[i] == 2'b01 && m_used[i]) &&
                    ({1'b0, m_lane[i][7:0]} < m_thr[i])) begin
                    m_on[i] = 1;
                    m_val[i] = (m_lane[i][15:8] > 8'd128);
                    m_cnt[i] = m_hold[i];
                    m_used[i] = 1;
                    m_hit[i] = 1;
                    m_perm[i] = (m_mode[i] == 2'b11);
                end
            end
            m_lane[i] = lfsr_next(m_lane[i]);
        end
    endtask

    typedef struct packed {
        logic [1:0]  idx;
        logic [1:0]  mode;
        logic [8:0]  thr;
        logic [3:0]  hold;
        logic [7:0]  nret;
        logic [15:0] wdata;
    } vec_t;

    // idx, mode, threshold, hold, retires, stored pattern
    localparam vec_t VECS [7] = '{
        '{2'd0, 2'b10, 9'd128, 4'd0, 8'd40, 16'h5A3C},  // R4 R5 R8 half threshold
        '{2'd1, 2'b10, 9'd256, 4'd0, 8'd20, 16'hC3A5},  // R8 R5 always fires
        '{2'd2, 2'b01, 9'd256, 4'd3, 8'd12, 16'h0FF0},  // R7 R6 single fault, hold 3
        '{2'd3, 2'b11, 9'd40,  4'd0, 8'd60, 16'h1357},  // R9 latching
        '{2'd0, 2'b10, 9'd0,   4'd0, 8'd30, 16'h2468},  // R4 zero threshold
        '{2'd1, 2'b00, 9'd256, 4'd0, 8'd20, 16'h9876},  // R10 off mode
        '{2'd2, 2'b10, 9'd64,  4'd2, 8'd50, 16'hBEEF}   // R6 R8 quarter, hold 2
    };

    int fires_seen;

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check_all("R1 reset state");

        // R2 plain write and read
        for (int i = 0; i < 4; i++) do_write(i, 16'h1000 + 16'(i) * 16'h0111);
        check_all("R2 write/read");

        // Table walk: R3 R4 R5 R6 R7 R8 R9 R10 R11
        foreach (VECS[v]) begin
            do_write(int'(VECS[v].idx), VECS[v].wdata);
            do_cfg(int'(VECS[v].idx), VECS[v].mode, VECS[v].thr, VECS[v].hold);
            check_all("R11 config clears");
            fires_seen = 0;
            for (int k = 0; k < int'(VECS[v].nret); k++) begin
                do_retire();
                if (m_on[VECS[v].idx]) fires_seen++;
                check_all("R3 R4 R5 R6 R7 R8 R9 R10 vector");
            end
            if (VECS[v].thr == 9'd0 || VECS[v].mode == 2'b00)
                check(fires_seen == 0, "R10 R4 no fault", 32'(fires_seen), 32'd0);
            if (VECS[v].mode == 2'b01)
                check(fires_seen == 4, "R7 R6 transient hold", 32'(fires_seen), 32'd4);
            do_cfg(int'(VECS[v].idx), 2'b00, 9'd0, 4'd0);
        end

        // R3 seed of zero: lane 0 substitutes 1, run reproducible
        do_seed(16'h0000);
        do_cfg(0, 2'b10, 9'd128, 4'd1);
        for (int k = 0; k < 24; k++) begin
            do_retire();
            check_all("R3 zero seed");
        end
        do_seed(16'h0000);
        do_cfg(0, 2'b10, 9'd128, 4'd1);
        for (int k = 0; k < 24; k++) begin
            do_retire();
            check_all("R3 reseed repeat");
        end
        do_cfg(0, 2'b00, 9'd0, 4'd0);

        // R12 write under a latched fault, then release by config
        do_seed(16'h7A31);
        do_cfg(3, 2'b11, 9'd256, 4'd0);
        do_retire();
        check(m_on[3] == 1'b1, "R9 latched fired", 32'(m_on[3]), 32'd1);
        check_all("R9 latched");
        do_write(3, 16'h1234);
        check_all("R12 write under fault");
        for (int k = 0; k < 5; k++) begin
            do_retire();
            check_all("R9 latched stays");
        end
        do_cfg(3, 2'b00, 9'd0, 4'd0);
        rd_idx = 2'd3;
        #0.5;
        check(rd_data == 16'h1234, "R12 stored value after release", 32'(rd_data), 32'h1234);
        check(hit_flags[3] == 1'b0, "R11 flag cleared", 32'(hit_flags[3]), 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule